// File: doc/BRIEF.md
# Shared Direct-Mapped Branch Target Buffer with Global Invalidate

This block sits beside the fetch stage and, in the same cycle that a fetch address is presented, tells the front end whether that address is a known branch, where the branch goes, and whether it is expected to jump. From these answers it produces the speculative address of the next fetch. The redirect is made from the address alone, before any decode of the instruction at that address.

The execute stage trains the table through a resolve port that carries the branch address, its outcome and its actual target. Each table slot holds a valid bit, an address tag, a full target address and a 2-bit saturating direction counter. The table has no notion of which hardware thread trained a slot. An address from either thread that matches a slot's tag hits it, so one thread's training steers the other's prediction. A single-cycle invalidate input clears every slot at once. It models the context-switch mitigation that leaves no earlier training in place.

Top module: `btb_top`

## Requirements
- R1: After reset every slot is invalid: `hit_o` is 0, `pred_taken_o` is 0 and `next_pc_o` equals `fetch_pc_i + 4` for any fetch address.
- R2: Lookup is combinational. The slot index is fetch address bits [IDX_W+1:2], and the tag is bits [PC_W-1:IDX_W+2]. `hit_o` is 1 exactly when the indexed slot is valid and its tag matches. On a hit, `pred_target_o` shows the stored target.
- R3: `next_pc_o` equals the stored target when the lookup hits and the counter is 2 or 3. In every other case it equals `fetch_pc_i + 4`. `pred_taken_o` is 1 exactly in the first case.
- R4: A taken resolve whose address misses allocates the indexed slot. The slot takes the tag and target, and its counter starts at 2 (weakly taken). A lookup sees the change only from the cycle after the resolve.
- R5: A taken resolve that hits increments the counter, saturating at 3, and rewrites the stored target with the resolved one.
- R6: A not-taken resolve that hits decrements the counter, saturating at 0. The slot stays valid.
- R7: A not-taken resolve that misses changes nothing. A later lookup of that address still misses.
- R8: A taken resolve whose index matches a valid slot with a different tag replaces that slot. The old address then misses.
- R9: A cycle with `flush_i` high invalidates every slot. Every lookup misses from the next cycle on.
- R10: When `flush_i` and a resolve arrive in the same cycle, the flush wins and the resolve leaves no trace.
- R11: A lookup has no thread input and depends on the address alone. A slot trained by one agent hits for any fetch of the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc_i | input | PC_W | Current fetch address |
| flush_i | input | 1 | Invalidate all slots (context switch) |
| rsv_valid_i | input | 1 | A branch resolution is presented |
| rsv_pc_i | input | PC_W | Address of the resolved branch |
| rsv_taken_i | input | 1 | Resolved direction, 1 = taken |
| rsv_target_i | input | PC_W | Resolved taken target |
| hit_o | output | 1 | Fetch address matches a valid slot |
| pred_taken_o | output | 1 | Hit with counter 2 or 3 |
| pred_target_o | output | PC_W | Target stored in the indexed slot |
| next_pc_o | output | PC_W | Speculative next fetch address |

## Verification
The bench builds the block with its defaults: 32-bit addresses and a 4-bit index, giving 16 slots and a 26-bit tag. With this geometry the chosen addresses can share an index while differing only in the tag. That brings slot replacement and the cross-agent hit within reach with only a few addresses. The small counter lets a handful of resolves walk one slot through both saturation limits and across the taken threshold in each direction.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // 2-bit direction counter; values 2 and 3 predict taken
    typedef enum logic [1:0] {
        CNT_STRONG_NT = 2'd0,
        CNT_WEAK_NT   = 2'd1,
        CNT_WEAK_T    = 2'd2,
        CNT_STRONG_T  = 2'd3
    } dir_cnt_e;

    localparam dir_cnt_e CNT_ON_ALLOC = CNT_WEAK_T;
    localparam int unsigned INSN_BYTES = 4;
    localparam int unsigned ALIGN_BITS = 2;

    function automatic dir_cnt_e cnt_up(input dir_cnt_e c);
        return (c == CNT_STRONG_T) ? CNT_STRONG_T : dir_cnt_e'(c + 2'd1);
    endfunction

    function automatic dir_cnt_e cnt_down(input dir_cnt_e c);
        return (c == CNT_STRONG_NT) ? CNT_STRONG_NT : dir_cnt_e'(c - 2'd1);
    endfunction

    function automatic logic cnt_says_taken(input dir_cnt_e c);
        return c[1];
    endfunction

endpackage

// File: rtl/btb_entry.sv
module btb_entry
    import btb_pkg::*;
#(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned TAG_W = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_i,
    input  logic             wr_en_i,
    input  logic             wr_taken_i,
    input  logic [TAG_W-1:0] wr_tag_i,
    input  logic [PC_W-1:0]  wr_target_i,
    output logic             valid_o,
    output logic [TAG_W-1:0] tag_o,
    output logic [PC_W-1:0]  target_o,
    output dir_cnt_e         cnt_o
);

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [PC_W-1:0]  target;
        dir_cnt_e         cnt;
    } slot_t;

    slot_t slot_q;
    logic  wr_match;

    assign wr_match = slot_q.valid && (slot_q.tag == wr_tag_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '{valid: 1'b0, tag: '0, target: '0, cnt: CNT_STRONG_NT};
        end else if (flush_i) begin
            slot_q.valid <= 1'b0;
        end else if (wr_en_i) begin
            if (wr_taken_i) begin
                slot_q.target <= wr_target_i;
                if (wr_match) begin
                    slot_q.cnt <= cnt_up(slot_q.cnt);
                end else begin
                    slot_q.valid <= 1'b1;
                    slot_q.tag   <= wr_tag_i;
                    slot_q.cnt   <= CNT_ON_ALLOC;
                end
            end else if (wr_match) begin
                slot_q.cnt <= cnt_down(slot_q.cnt);
            end
        end
    end

    assign valid_o  = slot_q.valid;
    assign tag_o    = slot_q.tag;
    assign target_o = slot_q.target;
    assign cnt_o    = slot_q.cnt;

    AST_ALLOC_WEAK: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_taken_i && !wr_match && !flush_i) |=> (valid_o && cnt_o == CNT_WEAK_T)); // R4
    AST_CNT_TOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_taken_i && wr_match && cnt_o == CNT_STRONG_T && !flush_i) |=> (cnt_o == CNT_STRONG_T)); // R5
    AST_CNT_FLOOR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !wr_taken_i && wr_match && cnt_o == CNT_STRONG_NT && !flush_i) |=> (valid_o && cnt_o == CNT_STRONG_NT)); // R6
    AST_NT_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
        (!valid_o && !(wr_en_i && wr_taken_i)) |=> !valid_o); // R7
    AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> !valid_o); // R10

endmodule

// File: rtl/btb_select.sv
module btb_select
    import btb_pkg::*;
#(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned IDX_W   = 4,
    parameter int unsigned TAG_W   = 26,
    parameter int unsigned ENTRIES = 16
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             valid_i  [ENTRIES],
    input  logic [TAG_W-1:0] tag_arr_i [ENTRIES],
    input  logic [PC_W-1:0]  tgt_arr_i [ENTRIES],
    input  dir_cnt_e         cnt_arr_i [ENTRIES],
    output logic             hit_o,
    output logic             taken_o,
    output logic [PC_W-1:0]  target_o
);

    always_comb begin
        hit_o    = valid_i[idx_i] && (tag_arr_i[idx_i] == tag_i);
        taken_o  = hit_o && cnt_says_taken(cnt_arr_i[idx_i]);
        target_o = tgt_arr_i[idx_i];
    end

endmodule

// File: rtl/btb_steer.sv
module btb_steer
    import btb_pkg::*;
#(
    parameter int unsigned PC_W = 32
) (
    input  logic [PC_W-1:0] fetch_pc_i,
    input  logic            taken_i,
    input  logic [PC_W-1:0] target_i,
    output logic [PC_W-1:0] next_pc_o
);

    logic [PC_W-1:0] seq_pc;

    assign seq_pc    = fetch_pc_i + PC_W'(INSN_BYTES);
    assign next_pc_o = taken_i ? target_i : seq_pc;

endmodule

// File: rtl/btb_top.sv
module btb_top
    import btb_pkg::*;
#(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] fetch_pc_i,
    input  logic            flush_i,
    input  logic            rsv_valid_i,
    input  logic [PC_W-1:0] rsv_pc_i,
    input  logic            rsv_taken_i,
    input  logic [PC_W-1:0] rsv_target_i,
    output logic            hit_o,
    output logic            pred_taken_o,
    output logic [PC_W-1:0] pred_target_o,
    output logic [PC_W-1:0] next_pc_o
);

    localparam int unsigned ENTRIES = 1 << IDX_W;
    localparam int unsigned TAG_LSB = IDX_W + ALIGN_BITS;
    localparam int unsigned TAG_W   = PC_W - TAG_LSB;

    logic [IDX_W-1:0] f_idx, r_idx;
    logic [TAG_W-1:0] f_tag, r_tag;
    logic [1:0]       unused_align;

    assign f_idx        = fetch_pc_i[TAG_LSB-1:ALIGN_BITS];
    assign f_tag        = fetch_pc_i[PC_W-1:TAG_LSB];
    assign r_idx        = rsv_pc_i[TAG_LSB-1:ALIGN_BITS];
    assign r_tag        = rsv_pc_i[PC_W-1:TAG_LSB];
    assign unused_align = fetch_pc_i[1:0] ^ rsv_pc_i[1:0];

    logic             e_valid [ENTRIES];
    logic [TAG_W-1:0] e_tag   [ENTRIES];
    logic [PC_W-1:0]  e_tgt   [ENTRIES];
    dir_cnt_e         e_cnt   [ENTRIES];

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
            btb_entry #(.PC_W(PC_W), .TAG_W(TAG_W)) u_entry (
                .clk         (clk),
                .rst         (rst),
                .flush_i     (flush_i),
                .wr_en_i     (rsv_valid_i && (r_idx == IDX_W'(g))),
                .wr_taken_i  (rsv_taken_i),
                .wr_tag_i    (r_tag),
                .wr_target_i (rsv_target_i),
                .valid_o     (e_valid[g]),
                .tag_o       (e_tag[g]),
                .target_o    (e_tgt[g]),
                .cnt_o       (e_cnt[g])
            );
        end
    endgenerate

    btb_select #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .ENTRIES(ENTRIES)) u_select (
        .idx_i     (f_idx),
        .tag_i     (f_tag),
        .valid_i   (e_valid),
        .tag_arr_i (e_tag),
        .tgt_arr_i (e_tgt),
        .cnt_arr_i (e_cnt),
        .hit_o     (hit_o),
        .taken_o   (pred_taken_o),
        .target_o  (pred_target_o)
    );

    btb_steer #(.PC_W(PC_W)) u_steer (
        .fetch_pc_i (fetch_pc_i),
        .taken_i    (pred_taken_o),
        .target_i   (pred_target_o),
        .next_pc_o  (next_pc_o)
    );

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> !hit_o); // R9
    AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        pred_taken_o |-> hit_o); // R3

endmodule

// File: tb/btb_top_test.sv
module btb_top_test;
    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            flush = 1'b0;
    logic            rv = 1'b0;
    logic [PC_W-1:0] rpc = '0;
    logic            rtk = 1'b0;
    logic [PC_W-1:0] rtgt = '0;
    logic            hit, ptk;
    logic [PC_W-1:0] ptgt, npc;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    btb_top uut (
        .clk(clk), .rst(rst), .fetch_pc_i(fetch_pc), .flush_i(flush),
        .rsv_valid_i(rv), .rsv_pc_i(rpc), .rsv_taken_i(rtk), .rsv_target_i(rtgt),
        .hit_o(hit), .pred_taken_o(ptk), .pred_target_o(ptgt), .next_pc_o(npc)
    );

    // A and C share index 4; B has index 8; D has index 12
    localparam logic [31:0] PA = 32'h1000_0010, PB = 32'h1000_0020;
    localparam logic [31:0] PC_ = 32'h2000_0010, PD = 32'h3000_0030;
    localparam logic [31:0] TA = 32'h0000_8000, TA2 = 32'h0000_9000;
    localparam logic [31:0] TB = 32'h0000_A000, TC = 32'h0000_C000;

    task automatic expect_look(input logic [31:0] pc, input logic eh, input logic et,
                               input logic [31:0] etgt, input string req);
        logic [31:0] enext;
        fetch_pc = pc;
        #1;
        enext = (eh && et) ? etgt : pc + 32'd4;
        checks++;
        if (hit !== eh || ptk !== et || npc !== enext || (eh && ptgt !== etgt)) begin
            fails++;
            $display("FAIL %s pc=%h hit=%b/%b taken=%b/%b next=%h/%h tgt=%h/%h (actual/expected)",
                     req, pc, hit, eh, ptk, et, npc, enext, ptgt, etgt);
        end
    endtask

    task automatic resolve(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
        @(negedge clk);
        rv = 1'b1; rpc = pc; rtk = tk; rtgt = tgt;
        @(negedge clk);
        rv = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    task automatic t_reset();
        expect_look(PA, 0, 0, 0, "R1");
        expect_look(PD, 0, 0, 0, "R1");
    endtask

    task automatic t_alloc();
        // same-cycle fetch of a resolving address still sees the old table
        @(negedge clk);
        rv = 1'b1; rpc = PA; rtk = 1'b1; rtgt = TA;
        expect_look(PA, 0, 0, 0, "R4");
        @(negedge clk);
        rv = 1'b0;
        expect_look(PA, 1, 1, TA, "R4");
        expect_look(PA, 1, 1, TA, "R11"); // no thread input: any fetch of PA hits
        expect_look(PB, 0, 0, 0, "R2");
    endtask

    task automatic t_counter();
        resolve(PA, 1, TA); resolve(PA, 1, TA); resolve(PA, 1, TA); // 2 -> 3 (held)
        resolve(PA, 0, 0);                                            // 3 -> 2
        expect_look(PA, 1, 1, TA, "R5");
        resolve(PA, 0, 0);                                            // 2 -> 1
        expect_look(PA, 1, 0, TA, "R3");
        resolve(PA, 0, 0); resolve(PA, 0, 0); resolve(PA, 0, 0);      // -> 0 (held)
        expect_look(PA, 1, 0, TA, "R6");
        resolve(PA, 1, TA);                                           // 0 -> 1
        expect_look(PA, 1, 0, TA, "R6");
        resolve(PA, 1, TA2);                                          // 1 -> 2, new target
        expect_look(PA, 1, 1, TA2, "R5");
    endtask

    task automatic t_nt_miss();
        resolve(PB, 0, TB);
        expect_look(PB, 0, 0, 0, "R7");
    endtask

    task automatic t_replace();
        resolve(PC_, 1, TC);
        expect_look(PC_, 1, 1, TC, "R8");
        expect_look(PA, 0, 0, 0, "R8");
    endtask

    task automatic t_flush();
        resolve(PA, 1, TA);
        resolve(PB, 1, TB);
        expect_look(PB, 1, 1, TB, "R9");
        do_flush();
        expect_look(PA, 0, 0, 0, "R9");
        expect_look(PB, 0, 0, 0, "R9");
        expect_look(PC_, 0, 0, 0, "R9");
        @(negedge clk);
        flush = 1'b1; rv = 1'b1; rpc = PD; rtk = 1'b1; rtgt = TA;
        @(negedge clk);
        flush = 1'b0; rv = 1'b0;
        expect_look(PD, 0, 0, 0, "R10");
        resolve(PD, 1, TA);
        expect_look(PD, 1, 1, TA, "R10");
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                t_reset();
                t_alloc();
                t_counter();
                t_nt_miss();
                t_replace();
                t_flush();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule